// File: doc/BRIEF.md
# Six-Pin GPIO Port Controller

This block is the general-purpose I/O port of a small microcontroller. It has six pins. Software writes a direction register and an output-data register through separate byte-wide strobes. The block turns those registers into output-enable, output-value and pull-up-enable controls for each pad cell. A global pull-up disable forces every pull-up off. Pin 5 has two roles, chosen by a configuration input. It is either the external reset pin, or a general input that can also pull the line low as an open-drain output. Pins 3 and 4 can be claimed by the oscillator, and while claimed they are silenced.

The input side never turns off. Every pin level passes through a two-flop synchronizer. The synchronized levels are then used in three places: readback, a pin-change detector that sets a sticky interrupt flag, and the alternate consumers. Those consumers are the external counter clock on pin 2 and the external interrupt on pin 1, and they see the pin level even when the port drives that pin itself. When reset is asserted, every driver and pull-up is released at once, without waiting for a clock edge.

Top module: `gpio_port_ctrl`

## Requirements
- R1: While `rst_n` is low, `pad_oe` and `pad_pu` are all zero, with no clock edge needed. After reset, `reg_dir` and `reg_dat` read 0.
- R2: An ordinary pin (0, 1 or 2, or 3 and 4 while unclaimed) with direction bit 1 has `pad_oe`=1, `pad_out` equal to its data bit, and `pad_pu`=0.
- R3: An ordinary pin with direction bit 0 has `pad_oe`=0. Its `pad_pu` equals its data bit while `pud`=0.
- R4: While `pud`=1, every bit of `pad_pu` is 0, whatever the direction and data bits are.
- R5: With `rst_pin_gpio`=0, pin 5 is the reset pin: `pad_oe[5]`=0, `pad_pu[5]`=0, and `ext_rst_n` follows `pin_in[5]` combinationally.
- R6: With `rst_pin_gpio`=1, `ext_rst_n` is 1. Pin 5 is enabled (`pad_oe[5]`=1) only when its direction bit is 1 and its data bit is 0. `pad_out[5]` is always 0. `pad_pu[5]` follows the R3 rule.
- R7: While `osc_claim`=1, `pad_oe` and `pad_pu` are 0 for pins 3 and 4, whatever the register values.
- R8: `rd_pins` shows `pin_in` after two rising clock edges.
- R9: `ext_tclk` and `ext_int` are the synchronized levels of pins 2 and 1. This holds even while those pins are outputs, so the port's own driven value reaches them.
- R10: A change in the synchronized level of any pin sets `pcf` on the third edge after the pin changes. No change is reported for the levels the synchronizer picks up while it fills after reset.
- R11: Pulsing `pcf_clr` clears `pcf` on the next edge. If a change is detected in the same cycle, the set wins and `pcf` stays 1.
- R12: `dir_we` loads only `reg_dir` and `dat_we` loads only `reg_dat`. Each register holds its value while its strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_we | input | 1 | Direction register write strobe |
| dat_we | input | 1 | Data register write strobe |
| wdata | input | 6 | Write data shared by both registers |
| pud | input | 1 | Global pull-up disable |
| rst_pin_gpio | input | 1 | 1: pin 5 is a general/open-drain pin; 0: pin 5 is the reset pin |
| osc_claim | input | 1 | 1: pins 3 and 4 belong to the oscillator |
| pcf_clr | input | 1 | Write-one pulse that clears the pin-change flag |
| pin_in | input | 6 | Raw pad input levels |
| pad_oe | output | 6 | Per-pin output enable |
| pad_out | output | 6 | Per-pin output value |
| pad_pu | output | 6 | Per-pin pull-up enable |
| rd_pins | output | 6 | Synchronized pin levels |
| reg_dir | output | 6 | Direction register value |
| reg_dat | output | 6 | Data register value |
| ext_tclk | output | 1 | External counter clock (synchronized pin 2) |
| ext_int | output | 1 | External interrupt source (synchronized pin 1) |
| ext_rst_n | output | 1 | External reset from pin 5, active low |
| pcf | output | 1 | Pin-change interrupt flag |

## Verification
The bench builds the block with its default parameters:
- six pins and a two-stage synchronizer;
- pin 5 as the open-drain/reset pin, pins 3 and 4 as the oscillator pair, and pins 2 and 1 as the counter-clock and interrupt taps.

With two stages, the readback latency is two edges and the flag latency is three, so both can be checked on exact cycles. With these pin roles, all three pin kinds sit in one six-bit port, so a single register write exercises the ordinary, oscillator and open-drain rules together. The bench also holds the pins high through reset, which shows the synchronizer filling without setting a spurious change flag.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [1:0] {
        ROLE_PLAIN = 2'd0,
        ROLE_OPEN_DRAIN = 2'd1,
        ROLE_CLAIMABLE = 2'd2
    } pin_role_t;

    function automatic pin_role_t role_of(input int idx, input int od_pin,
                                          input int osc_lo, input int osc_hi);
        if (idx == od_pin)
            return ROLE_OPEN_DRAIN;
        else if (idx == osc_lo || idx == osc_hi)
            return ROLE_CLAIMABLE;
        else
            return ROLE_PLAIN;
    endfunction

endpackage

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_we,
    input  logic         dat_we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] dir,
    output logic [W-1:0] dat
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] dat;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (dir_we) st_d.dir = wdata;
        if (dat_we) st_d.dat = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dir = st_q.dir;
    assign dat = st_q.dat;

    // R12: a register with its strobe low keeps its value
    p_dir_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_we |=> $stable(dir));
    p_dat_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !dat_we |=> $stable(dat));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++)
            st_d.stg[i] = st_q.stg[i-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout = st_q.stg[STAGES-1];

    // R8: the output stage takes what the first stage held one cycle earlier (two-stage build)
    generate
        if (STAGES == 2) begin : g_chk
            p_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> dout == $past(st_q.stg[0]));
        end
    endgenerate
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl
    import gpio_port_pkg::*;
#(
    parameter int W      = 6,
    parameter int OD_PIN = 5,
    parameter int OSC_LO = 3,
    parameter int OSC_HI = 4
) (
    input  logic         rst_n,
    input  logic [W-1:0] dir,
    input  logic [W-1:0] dat,
    input  logic         pud,
    input  logic         rst_pin_gpio,
    input  logic         osc_claim,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_pu
);
    typedef struct packed {
        logic oe;
        logic out;
        logic pu;
    } pad_t;

    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            localparam pin_role_t ROLE = role_of(i, OD_PIN, OSC_LO, OSC_HI);
            pad_t pad_d;

            always_comb begin
                pad_d.oe  = dir[i];
                pad_d.out = dat[i];
                pad_d.pu  = !dir[i] && dat[i] && !pud;
                if (ROLE == ROLE_OPEN_DRAIN) begin
                    pad_d.out = 1'b0;
                    pad_d.oe  = rst_pin_gpio && dir[i] && !dat[i];
                    if (!rst_pin_gpio) pad_d.pu = 1'b0;
                end else if (ROLE == ROLE_CLAIMABLE && osc_claim) begin
                    pad_d.oe = 1'b0;
                    pad_d.pu = 1'b0;
                end
                if (!rst_n) begin
                    pad_d.oe = 1'b0;
                    pad_d.pu = 1'b0;
                end
            end

            assign pad_oe[i]  = pad_d.oe;
            assign pad_out[i] = pad_d.out;
            assign pad_pu[i]  = pad_d.pu;
        end
    endgenerate

    // R1: reset releases every driver and pull-up without a clock
    always_comb begin
        if (!rst_n)
            p_release_in_reset_r1: assert (pad_oe == '0 && pad_pu == '0);
    end
endmodule

// File: rtl/gpio_pin_change.sv
module gpio_pin_change #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic         clr,
    output logic         flag
);
    localparam int ARM_N = STAGES + 1;
    localparam int CW    = $clog2(ARM_N + 1);

    typedef struct packed {
        logic [W-1:0]  prev;
        logic [CW-1:0] arm;
        logic          flag;
    } pc_t;

    pc_t  st_d, st_q;
    logic armed;
    logic hit;

    always_comb begin
        armed = (st_q.arm == CW'(ARM_N));
        hit   = armed && (lvl != st_q.prev);
        st_d      = st_q;
        st_d.prev = lvl;
        if (!armed) st_d.arm = st_q.arm + 1'b1;
        if (clr)    st_d.flag = 1'b0;
        if (hit)    st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R11: a detected change wins over a simultaneous clear
    p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    // R11: a clear without a change empties the flag
    p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !hit) |=> !flag);
    // R10: the flag only rises after a level change
    p_rise_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(hit));
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl #(
    parameter int NUM_PINS    = 6,
    parameter int SYNC_STAGES = 2,
    parameter int OD_PIN      = 5,
    parameter int OSC_LO_PIN  = 3,
    parameter int OSC_HI_PIN  = 4,
    parameter int TCLK_PIN    = 2,
    parameter int INT_PIN     = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                dir_we,
    input  logic                dat_we,
    input  logic [NUM_PINS-1:0] wdata,
    input  logic                pud,
    input  logic                rst_pin_gpio,
    input  logic                osc_claim,
    input  logic                pcf_clr,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_pu,
    output logic [NUM_PINS-1:0] rd_pins,
    output logic [NUM_PINS-1:0] reg_dir,
    output logic [NUM_PINS-1:0] reg_dat,
    output logic                ext_tclk,
    output logic                ext_int,
    output logic                ext_rst_n,
    output logic                pcf
);
    logic [NUM_PINS-1:0] lvl_sync;

    gpio_regs #(.W(NUM_PINS)) i_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .dir_we(dir_we),
        .dat_we(dat_we),
        .wdata (wdata),
        .dir   (reg_dir),
        .dat   (reg_dat)
    );

    gpio_pad_ctrl #(
        .W     (NUM_PINS),
        .OD_PIN(OD_PIN),
        .OSC_LO(OSC_LO_PIN),
        .OSC_HI(OSC_HI_PIN)
    ) i_pads (
        .rst_n       (rst_n),
        .dir         (reg_dir),
        .dat         (reg_dat),
        .pud         (pud),
        .rst_pin_gpio(rst_pin_gpio),
        .osc_claim   (osc_claim),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out),
        .pad_pu      (pad_pu)
    );

    gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (lvl_sync)
    );

    gpio_pin_change #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) i_pchg (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (lvl_sync),
        .clr  (pcf_clr),
        .flag (pcf)
    );

    assign rd_pins   = lvl_sync;
    assign ext_tclk  = lvl_sync[TCLK_PIN];
    assign ext_int   = lvl_sync[INT_PIN];
    assign ext_rst_n = rst_pin_gpio ? 1'b1 : pin_in[OD_PIN];

    // R4: the global disable silences every pull-up
    p_pud_all_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pud |-> pad_pu == '0);
    // R6: open-drain pin pulls low only on dir=1, data=0, and never drives high
    p_od_low_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pad_oe[OD_PIN] |-> (rst_pin_gpio && reg_dir[OD_PIN] && !reg_dat[OD_PIN]
                            && !pad_out[OD_PIN]));
    // R5: reset role keeps pin 5 undriven
    p_rst_role_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_pin_gpio |-> !pad_oe[OD_PIN] && !pad_pu[OD_PIN]);
    // R7: claimed oscillator pins are silent
    p_osc_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        osc_claim |-> !pad_oe[OSC_LO_PIN] && !pad_oe[OSC_HI_PIN]
                      && !pad_pu[OSC_LO_PIN] && !pad_pu[OSC_HI_PIN]);
endmodule

// File: tb/test_gpio_port_ctrl.sv
module test_gpio_port_ctrl;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dir_we, dat_we, pud, rst_pin_gpio, osc_claim, pcf_clr;
    logic [5:0] wdata, pin_in;
    logic [5:0] pad_oe, pad_out, pad_pu, rd_pins, reg_dir, reg_dat;
    logic       ext_tclk, ext_int, ext_rst_n, pcf;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_ctrl i_gpio_port_ctrl (
        .clk(clk), .rst_n(rst_n), .dir_we(dir_we), .dat_we(dat_we), .wdata(wdata),
        .pud(pud), .rst_pin_gpio(rst_pin_gpio), .osc_claim(osc_claim),
        .pcf_clr(pcf_clr), .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out),
        .pad_pu(pad_pu), .rd_pins(rd_pins), .reg_dir(reg_dir), .reg_dat(reg_dat),
        .ext_tclk(ext_tclk), .ext_int(ext_int), .ext_rst_n(ext_rst_n), .pcf(pcf)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_dir(input logic [5:0] v);
        wdata = v; dir_we = 1'b1; tick(1); dir_we = 1'b0;
    endtask

    task automatic wr_dat(input logic [5:0] v);
        wdata = v; dat_we = 1'b1; tick(1); dat_we = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(2); rst_n = 1'b1; tick(1);
    endtask

    // R1: reset values, and asynchronous release of drivers mid-cycle
    task automatic t_reset();
        check("R1", "dir after reset", reg_dir, 0);
        check("R1", "dat after reset", reg_dat, 0);
        wr_dir(6'h07); wr_dat(6'h07);
        check("R1", "oe before reset", pad_oe, 6'h07);
        #1 rst_n = 1'b0;
        #1;
        check("R1", "oe in reset no clock", pad_oe, 0);
        check("R1", "pu in reset", pad_pu, 0);
        tick(1); rst_n = 1'b1; tick(1);
        check("R1", "dir cleared", reg_dir, 0);
    endtask

    // R2: outputs on ordinary pins
    task automatic t_output();
        wr_dir(6'h1F); wr_dat(6'h15);
        check("R2", "oe", pad_oe & 6'h1F, 6'h1F);
        check("R2", "out", pad_out & 6'h1F, 6'h15);
        check("R2", "pu off", pad_pu & 6'h1F, 0);
    endtask

    // R3: inputs with and without pull-up
    task automatic t_input();
        wr_dir(6'h00); wr_dat(6'h0A);
        check("R3", "oe", pad_oe & 6'h1F, 0);
        check("R3", "pu follows data", pad_pu & 6'h1F, 6'h0A);
    endtask

    // R4: global disable
    task automatic t_pud();
        wr_dir(6'h00); wr_dat(6'h3F); rst_pin_gpio = 1'b1;
        #1 check("R4", "pu before disable", pad_pu, 6'h3F);
        pud = 1'b1; #1;
        check("R4", "pu with disable", pad_pu, 0);
        pud = 1'b0; rst_pin_gpio = 1'b0; tick(1);
    endtask

    // R5: pin 5 as reset pin
    task automatic t_pin5_rst();
        rst_pin_gpio = 1'b0; wr_dir(6'h20); wr_dat(6'h00);
        check("R5", "oe5", pad_oe[5], 0);
        wr_dir(6'h00); wr_dat(6'h20);
        check("R5", "pu5", pad_pu[5], 0);
        pin_in[5] = 1'b0; #1;
        check("R5", "ext_rst_n low", ext_rst_n, 0);
        pin_in[5] = 1'b1; #1;
        check("R5", "ext_rst_n high", ext_rst_n, 1);
        tick(4);
    endtask

    // R6: pin 5 as open-drain
    task automatic t_pin5_od();
        rst_pin_gpio = 1'b1; pin_in[5] = 1'b0; #1;
        check("R6", "ext_rst_n held", ext_rst_n, 1);
        wr_dir(6'h20); wr_dat(6'h00);
        check("R6", "pull low oe", pad_oe[5], 1);
        check("R6", "pull low out", pad_out[5], 0);
        wr_dat(6'h20);
        check("R6", "release on data1", pad_oe[5], 0);
        check("R6", "out never high", pad_out[5], 0);
        wr_dir(6'h00);
        check("R6", "pu5 input", pad_pu[5], 1);
        rst_pin_gpio = 1'b0; pin_in[5] = 1'b1; tick(4);
    endtask

    // R7: oscillator claim
    task automatic t_osc();
        wr_dir(6'h18); wr_dat(6'h18);
        osc_claim = 1'b1; #1;
        check("R7", "oe claimed", pad_oe & 6'h18, 0);
        wr_dir(6'h00);
        check("R7", "pu claimed", pad_pu & 6'h18, 0);
        osc_claim = 1'b0; #1;
        check("R7", "pu released", pad_pu & 6'h18, 6'h18);
    endtask

    // R8: two-edge readback
    task automatic t_readback();
        pin_in = 6'h2A; tick(1);
        check("R8", "one edge", rd_pins, 6'h3F);
        tick(1);
        check("R8", "two edges", rd_pins, 6'h2A);
        pin_in = 6'h3F; tick(3);
    endtask

    // R9: alternate taps see pin level while driven
    task automatic t_alt();
        wr_dir(6'h06); wr_dat(6'h00);
        pin_in = 6'h39; tick(2);
        check("R9", "tclk low", ext_tclk, 0);
        check("R9", "int low", ext_int, 0);
        pin_in = 6'h3F; tick(2);
        check("R9", "tclk high", ext_tclk, 1);
        check("R9", "int high", ext_int, 1);
        tick(2);
    endtask

    // R10, R11: pin change flag, clear, set-wins
    task automatic t_pchg();
        pcf_clr = 1'b1; tick(1); pcf_clr = 1'b0;
        check("R11", "cleared", pcf, 0);
        pin_in = 6'h3B; tick(2);
        check("R10", "not yet", pcf, 0);
        tick(1);
        check("R10", "set third edge", pcf, 1);
        pcf_clr = 1'b1; tick(1); pcf_clr = 1'b0;
        check("R11", "w1c", pcf, 0);
        pin_in = 6'h3F; tick(2);
        pcf_clr = 1'b1; tick(1);
        check("R11", "set wins", pcf, 1);
        tick(1); pcf_clr = 1'b0;
        check("R11", "later clear", pcf, 0);
    endtask

    // R10: no spurious flag from synchronizer filling after reset
    task automatic t_nospur();
        pin_in = 6'h3F; do_reset(); tick(6);
        check("R10", "no spurious", pcf, 0);
    endtask

    // R12: independent strobes
    task automatic t_strobes();
        wr_dir(6'h2D);
        wr_dat(6'h12);
        check("R12", "dir kept", reg_dir, 6'h2D);
        check("R12", "dat", reg_dat, 6'h12);
        wdata = 6'h3F; tick(2);
        check("R12", "hold dir", reg_dir, 6'h2D);
        check("R12", "hold dat", reg_dat, 6'h12);
    endtask

    initial begin
        rst_n = 1'b0; dir_we = 0; dat_we = 0; wdata = 0; pud = 0;
        rst_pin_gpio = 0; osc_claim = 0; pcf_clr = 0; pin_in = 6'h3F;
        tick(2); rst_n = 1'b1; tick(1);
        t_reset();
        t_nospur();
        t_output();
        t_input();
        t_pud();
        t_pin5_rst();
        t_pin5_od();
        t_osc();
        t_readback();
        t_alt();
        t_pchg();
        t_strobes();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule